// File: doc/BRIEF.md
# Serial-bus byte-access register slave

This block is a slave on a two-wire serial bus (SMBus-style). It lets a bus master write or read one byte at a time in a register space of up to 128 locations. The block oversamples the clock line and the data line with the system clock. From those samples it finds start, repeated-start and stop conditions, matches a fixed 7-bit device address, and acknowledges the phases it accepts by pulling the data line low. It never drives the line high: the output is an open-drain enable.

The master writes a register in one transaction:
1. It addresses the device with the direction bit clear.
2. It sends a command byte. The top bit of that byte must be set to mark a byte access, and its low seven bits give the register offset.
3. It sends one data byte. The block presents the byte on a register port with a one-cycle write strobe.

The master reads a register the same way up to the command byte. It then issues a repeated start, sends the device address again with the direction bit set, and clocks in one byte. The block takes that byte from the register port's read-data input at the offset it holds. The master ends the read with a not-acknowledge and a stop.

Top module: `smb_regslave`

## Requirements
- R1: While reset is asserted and right after it is released, the data-line pull-down enable `sda_oe_o` is 0 and `reg_we_o` is 0.
- R2: The block acknowledges an address byte equal to `SLAVE_ADDR`, sent MSB first with direction bit 0 (write) as its last bit. To acknowledge, it drives the data line low during the ninth clock of that byte.
- R3: An address byte that does not match gets no acknowledge. No later byte of that transaction is acknowledged, and no write takes place.
- R4: A command byte whose bit 7 is 1 is acknowledged, and its bits [6:0] then appear on `reg_addr_o` and stay there after the stop.
- R5: A command byte whose bit 7 is 0 is not acknowledged. Any data byte that follows it up to the next start is neither acknowledged nor written.
- R6: The data byte that follows an accepted command is acknowledged, assembled MSB first, and issued as a single `reg_we_o` pulse carrying the byte on `reg_wdata_o`. The pulse occurs while the sampled clock line is low and the acknowledge is being driven.
- R7: After a repeated start, the block acknowledges a matching address byte with direction bit 1 (read). It then shifts out, MSB first, the byte on `reg_rdata_i` at the held offset, and releases the line after the eighth bit.
- R8: `sda_oe_o` changes value only while the synchronised clock line is low.
- R9: A stop condition that arrives before the acknowledge slot of a data byte ends the transaction without a write. This holds even right after all eight data bits have been clocked in.
- R10: `reg_we_o` never stays high for two cycles in a row, and `reg_addr_o` holds steady in the cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| reg_addr_o | output | DATA_W-1 | Register offset from the last accepted command |
| reg_wdata_o | output | DATA_W | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | DATA_W | Byte at `reg_addr_o`, returned on reads |

## Verification
A data byte can finish assembling in the same cycle window in which the bus ends the transaction. The eighth rising clock edge marks the byte complete. If the master then raises the data line while the clock is still high, the stop arrives before the falling edge that would commit the write. The bench provokes this by clocking in eight data bits whose last bit is 0 and then issuing a stop with no ninth clock. It then counts write strobes and reads the register back to confirm that nothing was written. The repeated start of every read overlaps with the first bit slot of an expected data byte in the same way, and each read in the random run checks that the command is kept across it.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } smb_phase_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } smb_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    assign chain_d = {chain_q[STAGES-2:0], d_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
  import smb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output smb_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.scl_fall = ~scl_s & scl_q;
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
  import smb_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-2:0] SLAVE_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smb_evt_t          evt_i,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic [DATA_W-2:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o
);

  localparam int OFF_W = DATA_W - 1;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  smb_state_e        state_q, state_d;
  smb_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              rd_q, rd_d;
  logic              cmd_ok_q, cmd_ok_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    rd_d     = rd_q;
    cmd_ok_d = cmd_ok_q;
    off_d    = off_q;
    oe_d     = oe_q;
    we_d     = 1'b0;
    wdata_d  = wdata_q;

    if (evt_i.stop) begin
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      cmd_ok_d = 1'b0;
    end else if (evt_i.start) begin
      state_d  = ST_RX;
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
      // a repeated start lands in the first bit slot after the command ack
      if (!(state_q == ST_RX && phase_q == PH_DATA && bitcnt_q <= ONE))
        cmd_ok_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (evt_i.scl_rise && bitcnt_q != FULL) begin
            shreg_d  = {shreg_q[DATA_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + ONE;
          end else if (evt_i.scl_fall && bitcnt_q == FULL) begin
            bitcnt_d = '0;
            case (phase_q)
              PH_ADDR: begin
                if (shreg_q[DATA_W-1:1] == SLAVE_ADDR && (!shreg_q[0] || cmd_ok_q)) begin
                  state_d = ST_ACK;
                  oe_d    = 1'b1;
                  rd_d    = shreg_q[0];
                end else begin
                  state_d  = ST_IDLE;
                  cmd_ok_d = 1'b0;
                end
              end
              PH_CMD: begin
                if (shreg_q[DATA_W-1]) begin
                  state_d  = ST_ACK;
                  oe_d     = 1'b1;
                  off_d    = shreg_q[OFF_W-1:0];
                  cmd_ok_d = 1'b1;
                end else begin
                  state_d = ST_SKIP;
                end
              end
              default: begin
                state_d = ST_ACK;
                oe_d    = 1'b1;
                we_d    = 1'b1;
                wdata_d = shreg_q;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (evt_i.scl_fall) begin
            oe_d = 1'b0;
            case (phase_q)
              PH_ADDR: begin
                if (rd_q) begin
                  state_d  = ST_TX;
                  shreg_d  = rdata_i;
                  oe_d     = ~rdata_i[DATA_W-1];
                  bitcnt_d = '0;
                end else begin
                  state_d = ST_RX;
                  phase_d = PH_CMD;
                end
              end
              PH_CMD: begin
                state_d = ST_RX;
                phase_d = PH_DATA;
              end
              default: state_d = ST_SKIP;
            endcase
          end
        end
        ST_TX: begin
          if (evt_i.scl_rise && bitcnt_q != FULL) begin
            bitcnt_d = bitcnt_q + ONE;
          end else if (evt_i.scl_fall) begin
            if (bitcnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_SKIP;
            end else begin
              shreg_d = {shreg_q[DATA_W-2:0], 1'b0};
              oe_d    = ~shreg_q[DATA_W-2];
            end
          end
        end
        default: oe_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rd_q     <= 1'b0;
      cmd_ok_q <= 1'b0;
      off_q    <= '0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rd_q     <= rd_d;
      cmd_ok_q <= cmd_ok_d;
      off_q    <= off_d;
      oe_q     <= oe_d;
      we_q     <= we_d;
      wdata_q  <= wdata_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign addr_o   = off_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-2:0] SLAVE_ADDR  = 7'h69,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [DATA_W-2:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic     scl_s, sda_s;
  smb_evt_t evt;

  smb_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({sda_i, scl_i}),
    .q_o   ({sda_s, scl_s})
  );

  smb_cond_detect u_cond (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .evt_o (evt)
  );

  smb_byte_fsm #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt_i    (evt),
    .sda_s    (sda_s),
    .rdata_i  (reg_rdata_i),
    .sda_oe_o (sda_oe_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o),
    .we_o     (reg_we_o)
  );

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              reg_we_o,
  input logic [DATA_W-2:0] reg_addr_o
);

  p_drive_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> $stable(reg_addr_o));

  p_strobe_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !scl_s);

  p_strobe_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> sda_oe_o);

endmodule

bind smb_regslave smb_regslave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;

  localparam int H = 10;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic       m_scl, m_sda;
  logic       sda_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;
  wire        sda_bus = m_sda & ~sda_oe;

  smb_regslave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37) ^ 8'h5a);
  endfunction

  logic [7:0] regs [0:127];
  int we_count;
  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
      we_count <= 0;
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  int  viol;
  logic oe_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      viol = 0;
      oe_prev = 1'b0;
    end else begin
      if (sda_oe != oe_prev && m_scl) viol++;
      oe_prev = sda_oe;
    end
  end

  int checks = 0, errors = 0;
  logic [7:0] expm [0:127];
  int exp_writes = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    m_sda = b; w(H/2); m_scl = 1'b1; w(H); m_scl = 1'b0; w(H/2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; w(H/2); m_scl = 1'b1; w(H/2); b = sda_bus; w(H/2);
    m_scl = 1'b0; w(H/2);
  endtask

  task automatic bus_start;
    m_sda = 1'b0; w(H); m_scl = 1'b0; w(H/2);
  endtask

  task automatic bus_rstart;
    m_sda = 1'b1; w(H/2); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H);
    m_scl = 1'b0; w(H/2);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; w(H/2); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(1'b1);
  endtask

  task automatic do_write(logic [6:0] dev, logic [7:0] cmd, logic [7:0] data,
                          output logic [2:0] acks);
    bus_start;
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(data, acks[0]);
    bus_stop;
  endtask

  task automatic do_read(logic [7:0] cmd, output logic [7:0] data,
                         output logic [2:0] acks);
    bus_start;
    send_byte({DEV, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    bus_rstart;
    send_byte({DEV, 1'b1}, acks[0]);
    recv_byte(data);
    bus_stop;
  endtask

  logic [2:0] ak;
  logic [7:0] rv;

  initial begin
    logic [6:0] off;
    logic [7:0] dat;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 128; i++) expm[i] = init_val(i);
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    w(5);
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 we in reset", reg_we, 0);
    rst_n = 1'b1;
    w(10);
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 we after reset", reg_we, 0);

    // directed: boundary offsets
    do_write(DEV, 8'h80, 8'hc3, ak);
    chk("R2/R4/R6 acks offset 0", ak, 3'b111);
    chk("R4 offset on port", reg_addr, 0);
    chk("R6 written value", regs[0], 8'hc3);
    expm[0] = 8'hc3; exp_writes++;
    do_write(DEV, 8'hff, 8'h1e, ak);
    chk("R6 acks offset 127", ak, 3'b111);
    chk("R4 offset 127 on port", reg_addr, 127);
    expm[127] = 8'h1e; exp_writes++;
    do_read(8'h80, rv, ak);
    chk("R7 read acks", ak, 3'b111);
    chk("R7 read offset 0", rv, 8'hc3);
    do_read(8'hff, rv, ak);
    chk("R7 read offset 127", rv, 8'h1e);

    // R3 wrong address
    do_write(7'h2a, 8'h85, 8'h77, ak);
    chk("R3 no ack for wrong address", ak, 3'b000);
    do_read(8'h85, rv, ak);
    chk("R3 no write after mismatch", rv, expm[5]);

    // R5 command with bit 7 clear
    do_write(DEV, 8'h06, 8'h99, ak);
    chk("R5 cmd nack and data ignored", ak, 3'b100);
    do_read(8'h86, rv, ak);
    chk("R5 target unchanged", rv, expm[6]);

    // R9 stop in the middle of the data byte
    bus_start;
    send_byte({DEV, 1'b0}, ak[2]);
    send_byte(8'h87, ak[1]);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop;
    chk("R9 mid-byte stop no write", we_count, exp_writes);

    // R9 stop right after the eighth data bit, before the ack clock
    bus_start;
    send_byte({DEV, 1'b0}, ak[2]);
    send_byte(8'h88, ak[1]);
    for (int i = 7; i >= 1; i--) put_bit(1'b1);
    m_sda = 1'b0; w(H/2); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
    chk("R9 stop after eighth bit no write", we_count, exp_writes);
    do_read(8'h88, rv, ak);
    chk("R9 register kept", rv, expm[8]);

    // random traffic
    for (int n = 0; n < 24; n++) begin
      off = 7'($urandom % 128);
      dat = 8'($urandom);
      do_write(DEV, {1'b1, off}, dat, ak);
      chk("R2/R4/R6 random write acks", ak, 3'b111);
      expm[off] = dat; exp_writes++;
      do_read({1'b1, off}, rv, ak);
      chk("R7 random read acks", ak, 3'b111);
      chk("R7 random readback", rv, expm[off]);
      off = 7'($urandom % 128);
      do_read({1'b1, off}, rv, ak);
      chk("R7 random other offset", rv, expm[off]);
    end

    chk("R10 one strobe per write", we_count, exp_writes);
    chk("R8 oe changes only with scl low", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule